// File: doc/BRIEF.md
# SPI Interrupt and Soft-Reset Front-End

This block sits on the 32-bit register bus in front of an SPI serial engine. It turns the engine's one-cycle event pulses into sticky status bits. Software reads those bits and clears them by writing ones. The status bits are masked by a per-source enable register and by a single global enable, and the result drives one level-sensitive interrupt line.

A fourth register is write-only in effect. When software writes it with an exact key word, the block emits a reset pulse of fixed length to the serial engine. Any other value written there does nothing.

The bus is a simple single-cycle interface. A write is applied on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `spi_irq_front`

## Requirements
- R1: While reset is held and after its release, every register reads 0, `irqOut` is 0 and `coreRstOut` is 0.
- R2: Offset 0x1C holds the global enable. Only bit 31 is stored; every other bit reads back as 0.
- R3: Offset 0x20 reads the status bits. A one-cycle pulse on `eventIn[i]` sets status bit i on that clock edge, and the bit stays set. Source bits are: 0 mode fault, 1 slave mode fault, 2 TX FIFO empty (the last queued word has finished shifting out), 3 TX underrun, 4 RX full, 5 RX overrun, 6 TX FIFO half empty. Bits 31..7 read as 0.
- R4: Writing offset 0x20 clears exactly the status bits written as 1. Bits written as 0 are left unchanged, so writing back the value just read clears exactly those bits.
- R5: If an event pulse and a clear of the same status bit fall on one edge, the bit ends up set.
- R6: Offset 0x28 holds the per-source enable, with bit i for source i. Bits 31..7 read as 0, and writing 0 masks every source.
- R7: `irqOut` is 1 exactly when global enable bit 31 is 1 and at least one status bit is 1 whose enable bit is also 1. It follows register changes in the same cycle.
- R8: Writing exactly 0x0000000A to offset 0x40 drives `coreRstOut` high for RST_LEN cycles (default 4), starting at the edge of the write.
- R9: Writing any other value to offset 0x40 leaves `coreRstOut` unchanged. Offset 0x40 always reads as 0.
- R10: Writes to any offset other than 0x1C, 0x20, 0x28 and 0x40 change no register. Reads of those other offsets return 0.
- R11: Writing the key again while the reset pulse is active restarts the count, so `coreRstOut` stays high for RST_LEN further cycles from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, applied on the rising edge |
| busAddr | input | 8 | Byte offset for both read and write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| eventIn | input | 7 | One-cycle event pulses from the serial engine |
| irqOut | output | 1 | Level interrupt request |
| coreRstOut | output | 1 | Reset pulse to the serial engine |

## Verification
The bench builds the block with its default parameters: seven sources, a 32-bit bus and RST_LEN of 4. The short pulse lets the bench count the reset pulse to the exact cycle, including the restarted pulse. With seven sources, each source bit can be pulsed and cleared on its own, and the set-versus-clear collision can be aimed at one bit while its neighbours are cleared normally. Near-miss key values probe the key comparison, including one with the right low byte but extra high bits.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_GIE = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_ISR = 8'h20;
  localparam logic [REG_AW-1:0] OFS_IER = 8'h28;
  localparam logic [REG_AW-1:0] OFS_RST = 8'h40;

  // Strobes handed from the decoder to the register datapath
  typedef struct packed {
    logic gieWr;
    logic isrClr;
    logic ierWr;
    logic rstFire;
  } ctrlStb_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RST_LEN = 4,
  parameter logic [DATA_W-1:0] RST_KEY = 'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ctrlStb_t          stb,
  output logic              coreRstOut
);
  localparam int unsigned CNT_W = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_LEN);

  logic [CNT_W-1:0] rstCnt;

  // Write decode
  always_comb begin
    stb         = '0;
    stb.gieWr   = busWrEn && (busAddr == OFS_GIE);
    stb.isrClr  = busWrEn && (busAddr == OFS_ISR);
    stb.ierWr   = busWrEn && (busAddr == OFS_IER);
    stb.rstFire = busWrEn && (busAddr == OFS_RST) && (busWrData == RST_KEY);
  end

  // Reset pulse counter; a new key write reloads it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (stb.rstFire) begin
      rstCnt <= CNT_LOAD;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end

  assign coreRstOut = (rstCnt != '0);

  // R8
  key_starts_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_RST && busWrData == RST_KEY) |=> coreRstOut);

  // R9
  bad_key_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_RST && busWrData != RST_KEY && !coreRstOut)
      |=> !coreRstOut);

  // R8
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstCnt <= CNT_LOAD);
endmodule

// File: rtl/spi_irq_dp.sv
module spi_irq_dp
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [REG_AW-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut
);
  localparam int unsigned GIE_BIT = DATA_W - 1;
  localparam int unsigned PAD_W   = DATA_W - NUM_SRC;

  logic               gieQ;
  logic [NUM_SRC-1:0] ierQ;
  logic [NUM_SRC-1:0] isrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieQ <= 1'b0;
    end else if (stb.gieWr) begin
      gieQ <= busWrData[GIE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ <= '0;
    end else if (stb.ierWr) begin
      ierQ <= busWrData[NUM_SRC-1:0];
    end
  end

  // One sticky bit per source; a set wins over a clear on the same edge
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        isrQ[i] <= 1'b0;
      end else if (eventIn[i]) begin
        isrQ[i] <= 1'b1;
      end else if (stb.isrClr && busWrData[i]) begin
        isrQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_GIE: busRdData = {gieQ, {(DATA_W-1){1'b0}}};
      OFS_ISR: busRdData = {{PAD_W{1'b0}}, isrQ};
      OFS_IER: busRdData = {{PAD_W{1'b0}}, ierQ};
      default: busRdData = '0;
    endcase
  end

  assign irqOut = gieQ && |(isrQ & ierQ);

  // R3 R5
  event_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|eventIn) |=> ((isrQ & $past(eventIn)) == $past(eventIn)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.isrClr |=> ((isrQ & $past(busWrData[NUM_SRC-1:0]) & ~$past(eventIn)) == '0));

  // R10
  ier_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ierWr |=> $stable(ierQ));

  // R10
  gie_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.gieWr |=> $stable(gieQ));
endmodule

// File: rtl/spi_irq_front.sv
module spi_irq_front
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned RST_LEN = 4,
  parameter logic [DATA_W-1:0] RST_KEY = 'h0A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [REG_AW-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic               irqOut,
  output logic               coreRstOut
);
  ctrlStb_t stb;

  spi_irq_ctrl #(
    .DATA_W (DATA_W),
    .RST_LEN(RST_LEN),
    .RST_KEY(RST_KEY)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .stb       (stb),
    .coreRstOut(coreRstOut)
  );

  spi_irq_dp #(
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .eventIn  (eventIn),
    .busRdData(busRdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/spi_irq_front_tb.sv
module spi_irq_front_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [6:0]  eventIn = '0;
  logic        irqOut;
  logic        coreRstOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_irq_front u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .eventIn   (eventIn),
    .irqOut    (irqOut),
    .coreRstOut(coreRstOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic pulse(input logic [6:0] m);
    eventIn = m;
    @(negedge clk);
    eventIn = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h1C, v); chk("R1 gie", v, 0);
    rd(8'h20, v); chk("R1 isr", v, 0);
    rd(8'h28, v); chk("R1 ier", v, 0);
    chk("R1 irq", {31'd0, irqOut}, 0);
    chk("R1 rst", {31'd0, coreRstOut}, 0);
  endtask

  task automatic t_gie();
    logic [31:0] v;
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R2 only bit31", v, 32'h8000_0000);
    wr(8'h1C, 32'h7FFF_FFFF);
    rd(8'h1C, v); chk("R2 cleared", v, 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      rd(8'h20, v); chk("R3 source latch", v, 32'(1 << i));
      @(negedge clk);
      rd(8'h20, v); chk("R3 sticky", v, 32'(1 << i));
      wr(8'h20, 32'(1 << i));
      rd(8'h20, v); chk("R4 clear one", v, 0);
    end
  endtask

  task automatic t_clear();
    logic [31:0] v;
    pulse(7'h5A);
    rd(8'h20, v); chk("R3 multi", v, 32'h5A);
    wr(8'h20, 32'hFFFF_FF12);
    rd(8'h20, v); chk("R4 partial", v, 32'h48);
    wr(8'h20, v);
    rd(8'h20, v); chk("R4 writeback", v, 0);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    pulse(7'h03);
    eventIn = 7'h02;
    wr(8'h20, 32'h03);
    eventIn = '0;
    rd(8'h20, v); chk("R5 set wins", v, 32'h02);
    wr(8'h20, 32'h02);
  endtask

  task automatic t_ier();
    logic [31:0] v;
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, v); chk("R6 width", v, 32'h7F);
    wr(8'h28, 32'h0);
    rd(8'h28, v); chk("R6 mask all", v, 0);
  endtask

  task automatic t_irq();
    wr(8'h1C, 32'h8000_0000);
    wr(8'h28, 32'h04);
    pulse(7'h01);
    chk("R7 disabled src", {31'd0, irqOut}, 0);
    pulse(7'h04);
    chk("R7 asserted", {31'd0, irqOut}, 1);
    wr(8'h1C, 32'h0);
    chk("R7 global off", {31'd0, irqOut}, 0);
    wr(8'h1C, 32'h8000_0000);
    chk("R7 global on", {31'd0, irqOut}, 1);
    wr(8'h28, 32'h0);
    chk("R6 mask drops irq", {31'd0, irqOut}, 0);
    wr(8'h28, 32'h04);
    wr(8'h20, 32'h04);
    chk("R7 cleared", {31'd0, irqOut}, 0);
    wr(8'h20, 32'h7F);
    wr(8'h1C, 32'h0);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_rst_key();
    int n = 0;
    wr(8'h40, 32'h0000_000A);
    while (coreRstOut && n < 50) begin n++; @(negedge clk); end
    chk("R8 pulse length", 32'(n), 32'd4);
  endtask

  task automatic t_rst_bad();
    logic [31:0] v;
    int hits = 0;
    wr(8'h40, 32'h0000_000B);
    if (coreRstOut) hits++;
    wr(8'h40, 32'h0000_010A);
    if (coreRstOut) hits++;
    wr(8'h40, 32'h8000_000A);
    if (coreRstOut) hits++;
    wr(8'h40, 32'h0);
    if (coreRstOut) hits++;
    chk("R9 no pulse", 32'(hits), 0);
    rd(8'h40, v); chk("R9 reads zero", v, 0);
  endtask

  task automatic t_rst_restart();
    int n = 0;
    wr(8'h40, 32'h0000_000A);
    chk("R11 first high", {31'd0, coreRstOut}, 1);
    @(negedge clk);
    wr(8'h40, 32'h0000_000A);
    while (coreRstOut && n < 50) begin n++; @(negedge clk); end
    chk("R11 restarted", 32'(n), 32'd4);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h28, 32'h15);
    wr(8'h1C, 32'h8000_0000);
    pulse(7'h08);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h2C, 32'h0);
    wr(8'h00, 32'h0);
    rd(8'h28, v); chk("R10 ier kept", v, 32'h15);
    rd(8'h1C, v); chk("R10 gie kept", v, 32'h8000_0000);
    rd(8'h20, v); chk("R10 isr kept", v, 32'h08);
    chk("R10 no reset", {31'd0, coreRstOut}, 0);
    rd(8'h24, v); chk("R10 read 24", v, 0);
    rd(8'hFC, v); chk("R10 read FC", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_gie();
    t_events();
    t_clear();
    t_setwins();
    t_ier();
    t_irq();
    t_rst_key();
    t_rst_bad();
    t_rst_restart();
    t_unmapped();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule